// File: doc/BRIEF.md
# Temperature conversion sequencer

This block paces the conversions of an on-die temperature sensor and keeps the most recent result. A raw 12-bit two's-complement sample, in units of 1/16 degree, stands in for the analog front end. The block tells the front end when it captures that sample through a one-cycle strobe. How long a conversion takes depends on a 2-bit resolution code, measured in ticks of an external prescaled enable. Each result is cut down to the chosen precision and stored left-justified in a 16-bit temperature register. A one-cycle done pulse marks every new stored value for the thermostat logic downstream.

Out of reset the sequencer converts back to back at the coarsest resolution. A shutdown input stops it cleanly: the conversion already under way runs to its end and is stored, and then the block waits in standby. When shutdown is cleared, the next tick starts a fresh conversion. Any reader of the temperature register sees the last completed result and cannot disturb a conversion.

Top module: `tconv_seq`

## Requirements
- R1: While reset is held and right after it is released, busy=1, done=0 and tempReg=16'h0000. The first conversion after reset always uses code 00 and lasts BASE_TICKS ticks, whatever resCode holds.
- R2: A conversion lasts BASE_TICKS << code ticks. Code 00 means 9 bits (x1), 01 means 10 bits (x2), 10 means 11 bits (x4) and 11 means 12 bits (x8). The count covers the rising edges with tick high, from the first tick of the conversion through the completing tick.
- R3: On capture, tempReg[15:4] = rawSample with its lowest (3 - code) bits cleared, and tempReg[3:0] = 0. Bit 15 is therefore the sign.
- R4: sampleTake is high for exactly the cycle whose closing edge captures rawSample. done is high for exactly one cycle, the cycle after that edge, and tempReg shows the new value in that same cycle.
- R5: If shutdown is low at the completing edge, the next conversion starts on that same edge and busy stays 1.
- R6: shutdown is sampled only at the completing edge. If it is high there, the result is still stored, and busy falls in the same cycle that done rises. After that, no done occurs while shutdown stays high. A shutdown pulse that ends before the completing edge has no effect.
- R7: When shutdown is cleared in standby, the next tick starts a conversion and is not counted toward its length. done then follows 1 + (BASE_TICKS << code) ticks after the clear.
- R8: tempReg keeps its value between done pulses. rawSample is ignored except at the capture edge, including in standby.
- R9: The resolution code is latched when a conversion starts. Changes to resCode during a conversion alter neither its length nor its truncation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled timing enable; one tick counts one unit of conversion time |
| resCode | input | 2 | Resolution code, 00 = 9 bits up to 11 = 12 bits |
| shutdown | input | 1 | Request to stop after the current conversion |
| rawSample | input | 12 | Raw two's-complement sample, 1/16 degree per LSB |
| sampleTake | output | 1 | High in the cycle the raw sample is captured |
| tempReg | output | 16 | Last completed result, left-justified, low nibble zero |
| done | output | 1 | One-cycle pulse when a new result is stored |
| busy | output | 1 | High while a conversion is in progress |

## Verification
Some properties are checked by assertions on every cycle. These cover:
- the stored value holding still between captures;
- truncated bits reading zero after a capture;
- done being a single-cycle pulse that always follows sampleTake;
- the latched code staying fixed until a conversion completes;
- standby persisting while shutdown is high, with no done pulse in standby.

Other behaviour only the bench scenarios can show: the exact tick count of each resolution, the arithmetic value stored for a sweep of raw samples at all four codes, and how a shutdown request is timed against the completing tick. The same goes for the one-tick start-up delay when leaving standby.

// File: rtl/tconv_pkg.sv
package tconv_pkg;

  typedef enum logic {
    ST_CONV    = 1'b0,
    ST_STANDBY = 1'b1
  } convState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       store;  // capture rawSample on this edge
    logic [1:0] res;    // resolution code of the finishing conversion
  } convCmd_t;

  localparam int RAW_W  = 12;
  localparam int TEMP_W = 16;
  localparam int PAD_W  = TEMP_W - RAW_W;

  // Keep the top (9 + code) bits of the raw sample
  function automatic logic [RAW_W-1:0] maskFor(input logic [1:0] res);
    return {RAW_W{1'b1}} << (2'd3 - res);
  endfunction

endpackage

// File: rtl/tconv_ctrl.sv
module tconv_ctrl
  import tconv_pkg::*;
#(
  parameter int BASE_TICKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] resCode,
  input  logic       shutdown,
  output convCmd_t   cmd,
  output logic       busy
);

  localparam int CW = $clog2(BASE_TICKS * 8 + 1);

  convState_t    state;
  logic [CW-1:0] count;
  logic [CW-1:0] durTicks;
  logic [1:0]    resLatched;
  logic          lastTick;

  assign durTicks = CW'(BASE_TICKS) << resLatched;
  assign lastTick = tick && (count == durTicks - CW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_CONV;
      count      <= '0;
      resLatched <= 2'b00;
    end else begin
      case (state)
        ST_CONV: begin
          if (tick) begin
            if (lastTick) begin
              count <= '0;
              if (shutdown) begin
                state <= ST_STANDBY;
              end else begin
                resLatched <= resCode;
              end
            end else begin
              count <= count + CW'(1);
            end
          end
        end
        ST_STANDBY: begin
          if (tick && !shutdown) begin
            state      <= ST_CONV;
            count      <= '0;
            resLatched <= resCode;
          end
        end
        default: state <= ST_CONV;
      endcase
    end
  end

  assign busy      = (state == ST_CONV);
  assign cmd.store = (state == ST_CONV) && lastTick;
  assign cmd.res   = resLatched;

  // R2: the tick counter never runs past the latched duration
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (count < durTicks))
    else $error("tick counter beyond conversion length");

  // R6: standby persists while shutdown is held
  assert_standby_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STANDBY && shutdown) |=> (state == ST_STANDBY))
    else $error("left standby with shutdown high");

  // R9: latched code fixed until the completing tick
  assert_res_fixed_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastTick) |=> $stable(resLatched))
    else $error("resolution changed mid-conversion");

endmodule

// File: rtl/tconv_dp.sv
module tconv_dp
  import tconv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  convCmd_t          cmd,
  input  logic [RAW_W-1:0]  rawSample,
  output logic [TEMP_W-1:0] tempReg,
  output logic              done
);

  logic [RAW_W-1:0] truncated;

  assign truncated = rawSample & maskFor(cmd.res);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempReg <= '0;
      done    <= 1'b0;
    end else begin
      done <= cmd.store;
      if (cmd.store) begin
        tempReg <= {truncated, {PAD_W{1'b0}}};
      end
    end
  end

  // R8: stored value holds when no capture happens
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.store |=> $stable(tempReg))
    else $error("temperature register changed without capture");

  // R3: bits below the selected precision read zero after a capture
  assert_trunc_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.store |=> ((tempReg[TEMP_W-1:PAD_W] & ~maskFor($past(cmd.res))) == '0))
    else $error("bits below resolution not cleared");

  // R4: done lasts a single cycle
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done)
    else $error("done longer than one cycle");

endmodule

// File: rtl/tconv_seq.sv
module tconv_seq
  import tconv_pkg::*;
#(
  parameter int BASE_TICKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic [1:0]  resCode,
  input  logic        shutdown,
  input  logic [11:0] rawSample,
  output logic        sampleTake,
  output logic [15:0] tempReg,
  output logic        done,
  output logic        busy
);

  convCmd_t cmd;

  tconv_ctrl #(.BASE_TICKS(BASE_TICKS)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .resCode (resCode),
    .shutdown(shutdown),
    .cmd     (cmd),
    .busy    (busy)
  );

  tconv_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .rawSample(rawSample),
    .tempReg  (tempReg),
    .done     (done)
  );

  assign sampleTake = cmd.store;

  // R4: every capture is followed by done on the next cycle
  assert_take_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    sampleTake |=> done)
    else $error("capture without done");

  // R6: no result is reported while idling in standby
  assert_no_done_standby_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> !done)
    else $error("done pulse in standby");

  // R5: a result only comes from a running conversion
  assert_done_from_conv_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy))
    else $error("done without a conversion");

endmodule

// File: tb/tconv_seq_tb_top.sv
`timescale 1ns/1ps
module tconv_seq_tb_top;

  localparam int BASE = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  resCode = 2'b00;
  logic        shutdown = 1'b0;
  logic [11:0] rawSample = '0;
  logic        sampleTake;
  logic [15:0] tempReg;
  logic        done;
  logic        busy;

  tconv_seq #(.BASE_TICKS(BASE)) dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .resCode(resCode),
    .shutdown(shutdown), .rawSample(rawSample), .sampleTake(sampleTake),
    .tempReg(tempReg), .done(done), .busy(busy)
  );

  always #10 clk = ~clk;

  // tick every third cycle, driven away from the active edge
  int tickPhase = 0;
  always @(negedge clk) begin
    tickPhase <= (tickPhase == 2) ? 0 : tickPhase + 1;
    tick      <= (tickPhase == 2);
  end

  int tickSeen = 0;
  always @(posedge clk) if (rstN && tick) tickSeen <= tickSeen + 1;

  int checks = 0;
  int fails  = 0;
  int lastMark = 0;
  int convRes = 0;
  logic [11:0] curRaw = '0;
  logic [15:0] lastTemp = '0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expTemp(input logic [11:0] raw, input int res);
    logic [11:0] m;
    m = 12'hFFF << (3 - res);
    return {raw & m, 4'h0};
  endfunction

  function automatic logic [11:0] rawPick(input int k, input int r);
    case (k)
      0: return 12'h7D0;   // +125
      1: return 12'hC90;   // -55
      2: return 12'h191;   // +25.0625
      3: return 12'hF5E;   // -10.125
      4: return 12'hFFF;
      5: return 12'h800;
      6: return 12'h00F;
      default: return 12'h5A5 ^ 12'(r * 12'h111);
    endcase
  endfunction

  // Wait for the done pulse of the conversion in progress and check it.
  task automatic finishConv(input int expDur, input bit expBusy, input string tag);
    int waited;
    bit holdBad;
    logic [15:0] badVal;
    logic [15:0] exp;
    waited = 0;
    holdBad = 0;
    badVal = '0;
    @(negedge clk);
    check(done == 1'b0, "R4 done width", 32'(done), 32'h0);
    while (!done) begin
      if (tempReg !== lastTemp) begin
        holdBad = 1;
        badVal = tempReg;
      end
      waited++;
      if (waited > 400) begin
        check(1'b0, {tag, " watchdog"}, 32'(waited), 32'(expDur));
        return;
      end
      @(negedge clk);
    end
    exp = expTemp(curRaw, convRes);
    check(tickSeen - lastMark == expDur, tag, 32'(tickSeen - lastMark), 32'(expDur));
    check(tempReg == exp, "R3 stored value", 32'(tempReg), 32'(exp));
    check(!holdBad, "R8 hold between results", 32'(badVal), 32'(lastTemp));
    check(busy == expBusy, "R5 R6 busy after completion", 32'(busy), 32'(expBusy));
    lastMark = tickSeen;
    lastTemp = exp;
    convRes  = int'(resCode);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R1 busy in reset", 32'(busy), 32'h1);
    check(done == 1'b0, "R1 done in reset", 32'(done), 32'h0);
    check(tempReg == 16'h0, "R1 tempReg in reset", 32'(tempReg), 32'h0);

    // release reset with a fine code pending: first conversion still 9-bit
    rstN      = 1'b1;
    resCode   = 2'b11;
    rawSample = 12'h7D7;
    curRaw    = rawSample;
    convRes   = 0;
    finishConv(BASE, 1'b1, "R1 first conversion length");

    // sweep all codes over a set of raw samples (R2, R3, R5, R9)
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 8; k++) begin
        resCode   = 2'(r);
        rawSample = rawPick(k, r);
        curRaw    = rawSample;
        finishConv(BASE << convRes, 1'b1, "R2 R9 conversion length");
      end
    end

    // shutdown requested mid-conversion (R6)
    resCode   = 2'b01;
    rawSample = 12'h3C4;
    curRaw    = rawSample;
    shutdown  = 1'b1;
    finishConv(BASE << convRes, 1'b0, "R6 last conversion length");

    // standby: raw changes ignored, no results
    begin
      bit sawActivity;
      bit sawChange;
      sawActivity = 0;
      sawChange = 0;
      rawSample = 12'h555;
      resCode   = 2'b10;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (done || busy) sawActivity = 1;
        if (tempReg !== lastTemp) sawChange = 1;
      end
      check(!sawActivity, "R6 quiet standby", 32'(sawActivity), 32'h0);
      check(!sawChange, "R8 standby hold", 32'(tempReg), 32'(lastTemp));
    end

    // leave standby (R7)
    shutdown  = 1'b0;
    lastMark  = tickSeen;
    convRes   = 2;
    rawSample = 12'h9A7;
    curRaw    = rawSample;
    finishConv(1 + (BASE << 2), 1'b1, "R7 restart length");

    // short shutdown pulse that ends before completion (R6)
    rawSample = 12'hE6F;
    curRaw    = rawSample;
    resCode   = 2'b00;
    shutdown  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    shutdown  = 1'b0;
    finishConv(BASE << convRes, 1'b1, "R6 pulse ignored length");

    rawSample = 12'h0A2;
    curRaw    = rawSample;
    finishConv(BASE << convRes, 1'b1, "R5 continues after pulse");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule